// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store port and a word-wide main-memory port. It keeps 1024 single-word lines. Each line has a valid flag and an address tag. The byte address is split three ways:

- bits [1:0] select the byte within the word;
- bits [11:2] select the line;
- bits [31:12] form the tag.

A load that finds its word returns it combinationally in the same cycle. A load that misses holds the processor stalled while the word is fetched. The word is then written into its line, and the held access completes as a hit.

Stores use a write-through policy. Every store is queued in a four-entry FIFO together with its byte-enable mask. The FIFO drains to memory one entry per transaction whenever the memory port is free. A store that finds its line also merges the enabled bytes into that line. A store that misses leaves the cache untouched.

The processor is stalled on a store only when the FIFO is full. A load miss is not sent to memory until the FIFO is empty, so the fetched word already includes every earlier store.

The processor must hold its request steady for as long as the stall output is high. The memory side keeps one transaction outstanding at a time. The request stays asserted until a single-cycle acknowledge. On a read, the returned word is valid in the acknowledge cycle.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid, so the first load to any address stalls for at least one cycle and is served from memory.
- R2: Bits [11:2] of the address choose the line and bits [31:12] are compared with its tag; bits [1:0] take no part. A load to a line holding a different tag misses, and the fill replaces that line.
- R3: A load whose line is valid with a matching tag completes with stall low and returns the line's word in the same cycle.
- R4: On a load miss, stall stays high while the memory read is outstanding. The word is written into the line, and in the cycle after the read acknowledge the held load completes with stall low, returning that word.
- R5: A store that hits changes only the bytes whose enable bit is set (enable bit b covers data bits 8b+7 down to 8b), and the line stays valid, so a following load hits and returns the merged word.
- R6: Every store reaches main memory with its own byte-enable mask, so memory ends up holding the same words as the processor's view.
- R7: Stores enter a FIFO of WB_DEPTH entries (4 by default). A store stalls only when the FIFO is full, so with an empty FIFO four stores in a row complete without stall and a fifth stalls.
- R8: A store that misses does not allocate a line, and a later load to that address still misses.
- R9: A load miss is not issued to memory until the FIFO is empty, so it returns the newest stored value of its word.
- R10: The memory request, address, write flag and data stay unchanged until acknowledged. Buffered stores reach memory in program order, so the later of two stores to one word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor access request |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Store data |
| cpu_be_i | input | 4 | Store byte enables |
| cpu_rdata_o | output | 32 | Load data, valid when stall is low |
| cpu_stall_o | output | 1 | Processor must hold the access |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = memory write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory write byte enables |
| mem_ack_i | input | 1 | Single-cycle transaction acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
The hardest situation to reach from the ports is a load miss that arrives while stores are still waiting in the FIFO. In that case the read must wait for the drain and must then return the buffered value, not the stale memory word.

The stimulus targets it in two ways:
- Directed sequences store to an uncached word and load it back at once, including two stores to one word back to back.
- A random phase mixes loads and masked stores over a few colliding indices and tags, with a memory latency that changes per access so the FIFO fill level varies.

A separate directed case raises the memory latency to fill the FIFO and checks exactly which store first stalls.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int OFF_W  = $clog2(BE_W);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } wb_entry_t;
endpackage

// File: rtl/dcache_wbuf.sv
module dcache_wbuf
  import dcache_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  wb_entry_t        entry_i,
  input  logic             pop_i,
  output wb_entry_t        head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  wb_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_o  = slot_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (push_i) slot_q[wr_ptr_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dcache_array.sv
module dcache_array
  import dcache_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];

  for (genvar b = 0; b < BE_W; b++) begin : g_bank
    logic [7:0] bank_q [LINES];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_be_i[b]) bank_q[wr_idx_i] <= wr_data_i[8*b +: 8];
    end
    assign rd_data_o[8*b +: 8] = bank_q[rd_idx_i];
  end
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt
  import dcache_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int WB_DEPTH = 4,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int CNT_W = $clog2(WB_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic [BE_W-1:0]   cpu_be_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [BE_W-1:0]   mem_be_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [IDX_W-1:0]  cpu_idx;
  logic [TAG_W-1:0]  cpu_tag;
  logic [ADDR_W-1:0] cpu_word_addr;
  logic              line_valid, hit, rd_miss;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;

  assign cpu_idx       = cpu_addr_i[OFF_W +: IDX_W];
  assign cpu_tag       = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_word_addr = {cpu_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign hit           = line_valid && (line_tag == cpu_tag);
  assign rd_miss       = cpu_req_i && !cpu_we_i && !hit;

  // write buffer
  wb_entry_t        wb_head, wb_in;
  logic [CNT_W-1:0] wb_cnt;
  logic             wb_full, wb_empty, wb_push, wb_pop;

  // memory port state
  logic              port_busy_q, port_rd_q;
  logic [ADDR_W-1:0] port_addr_q;
  logic [DATA_W-1:0] port_data_q;
  logic [BE_W-1:0]   port_be_q;

  assign wb_in   = '{addr: cpu_word_addr, data: cpu_wdata_i, be: cpu_be_i};
  assign wb_push = cpu_req_i && cpu_we_i && !wb_full;
  assign wb_pop  = port_busy_q && !port_rd_q && mem_ack_i;

  dcache_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wb_push),
    .entry_i (wb_in),
    .pop_i   (wb_pop),
    .head_o  (wb_head),
    .count_o (wb_cnt),
    .full_o  (wb_full),
    .empty_o (wb_empty)
  );

  // drain has priority; a read miss waits for an empty buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_busy_q <= 1'b0;
      port_rd_q   <= 1'b0;
      port_addr_q <= '0;
      port_data_q <= '0;
      port_be_q   <= '0;
    end else if (port_busy_q) begin
      if (mem_ack_i) port_busy_q <= 1'b0;
    end else if (!wb_empty) begin
      port_busy_q <= 1'b1;
      port_rd_q   <= 1'b0;
      port_addr_q <= wb_head.addr;
      port_data_q <= wb_head.data;
      port_be_q   <= wb_head.be;
    end else if (rd_miss) begin
      port_busy_q <= 1'b1;
      port_rd_q   <= 1'b1;
      port_addr_q <= cpu_word_addr;
      port_data_q <= '0;
      port_be_q   <= '1;
    end
  end

  assign mem_req_o   = port_busy_q;
  assign mem_we_o    = port_busy_q && !port_rd_q;
  assign mem_addr_o  = port_addr_q;
  assign mem_wdata_o = port_data_q;
  assign mem_be_o    = port_be_q;

  // line update: fill on read ack, merge on store hit
  logic              fill, st_hit, arr_we;
  logic [IDX_W-1:0]  arr_idx;
  logic [TAG_W-1:0]  arr_tag;
  logic [DATA_W-1:0] arr_data;
  logic [BE_W-1:0]   arr_be;

  assign fill   = port_busy_q && port_rd_q && mem_ack_i;
  assign st_hit = wb_push && hit;
  assign arr_we = fill || st_hit;

  always_comb begin
    if (fill) begin
      arr_idx  = port_addr_q[OFF_W +: IDX_W];
      arr_tag  = port_addr_q[ADDR_W-1 -: TAG_W];
      arr_data = mem_rdata_i;
      arr_be   = '1;
    end else begin
      arr_idx  = cpu_idx;
      arr_tag  = cpu_tag;
      arr_data = cpu_wdata_i;
      arr_be   = cpu_be_i;
    end
  end

  dcache_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (cpu_idx),
    .rd_valid_o (line_valid),
    .rd_tag_o   (line_tag),
    .rd_data_o  (line_data),
    .wr_en_i    (arr_we),
    .wr_idx_i   (arr_idx),
    .wr_tag_i   (arr_tag),
    .wr_data_i  (arr_data),
    .wr_be_i    (arr_be)
  );

  assign cpu_rdata_o = line_data;
  assign cpu_stall_o = cpu_req_i && (cpu_we_i ? wb_full : !hit);
endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
  parameter int WB_DEPTH = 4,
  parameter int CNT_W    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_req_i,
  input logic             cpu_we_i,
  input logic [31:0]      cpu_addr_i,
  input logic             cpu_stall_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [31:0]      mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic             mem_ack_i,
  input logic [CNT_W-1:0] wb_cnt_i
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R10
  AST_WB_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_cnt_i <= CNT_W'(WB_DEPTH)); // R7
  AST_STORE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i && (wb_cnt_i < CNT_W'(WB_DEPTH)) |-> !cpu_stall_o); // R7
  AST_READ_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && !mem_we_o |-> wb_cnt_i == '0); // R9
  AST_MISS_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_we_i && mem_req_o && !mem_we_o |-> cpu_stall_o); // R4
  AST_FILL_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i && cpu_req_i && !cpu_we_i
    |=> !(cpu_req_i && !cpu_we_i && $stable(cpu_addr_i)) || !cpu_stall_o); // R4
endmodule

bind dcache_wt dcache_wt_chk #(.WB_DEPTH(WB_DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_stall_o (cpu_stall_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .wb_cnt_i    (wb_cnt)
);

// File: tb/dcache_wt_tb_top.sv
`timescale 1ns/1ps
module dcache_wt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  int n_chk = 0, n_fail = 0, cycles = 0, lat = 3, mcnt = 0;
  bit done = 1'b0;
  logic [31:0] mem_m  [int unsigned];
  logic [31:0] gold_m [int unsigned];

  always #2.5 clk = ~clk;

  dcache_wt dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_be_i(cpu_be),
    .cpu_rdata_o(cpu_rdata), .cpu_stall_o(cpu_stall),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] init_word(input int unsigned w);
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mem_get(input int unsigned w);
    return mem_m.exists(w) ? mem_m[w] : init_word(w);
  endfunction

  function automatic logic [31:0] gold_get(input int unsigned w);
    return gold_m.exists(w) ? gold_m[w] : init_word(w);
  endfunction

  // main memory model with programmable latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; mcnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (mcnt >= lat) begin
        mem_ack <= 1'b1;
        mcnt    <= 0;
        if (mem_we) mem_m[mem_addr[31:2]] = merge(mem_get(mem_addr[31:2]), mem_wdata, mem_be);
        else        mem_rdata <= mem_get(mem_addr[31:2]);
      end else mcnt <= mcnt + 1;
    end
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=completion");
      report();
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    stalls = 0;
    forever begin
      #1;
      if (!cpu_stall) break;
      stalls++;
      @(negedge clk);
    end
    rd = cpu_rdata;
    @(posedge clk);
    if (we) gold_m[a[31:2]] = merge(gold_get(a[31:2]), d, be);
    #1 cpu_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd, a_w, b_w, c_w, d_w, exp_w;
    int st, s4, seed;
    seed = $urandom(1234);
    a_w = 32'h0000_1040; b_w = 32'h0000_2040;
    c_w = 32'h0000_3080; d_w = 32'h0000_40C0;
    idle(3);
    #1 chk("R1 reset stall", {31'b0, cpu_stall}, 32'd0);
    chk("R1 reset mem_req", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    access(0, a_w, 0, 0, rd, st);
    chk("R1 first load misses", {31'b0, st > 0}, 32'd1);
    chk("R4 fill data", rd, init_word(a_w[31:2]));
    access(0, a_w, 0, 0, rd, st);
    chk("R3 hit no stall", st, 0);
    chk("R3 hit data", rd, init_word(a_w[31:2]));
    access(0, a_w | 32'h3, 0, 0, rd, st);
    chk("R2 offset ignored", st, 0);
    chk("R2 offset data", rd, init_word(a_w[31:2]));
    access(0, b_w, 0, 0, rd, st);
    chk("R2 tag mismatch misses", {31'b0, st > 0}, 32'd1);
    chk("R2 conflict data", rd, init_word(b_w[31:2]));
    access(0, a_w, 0, 0, rd, st);
    chk("R2 evicted line misses", {31'b0, st > 0}, 32'd1);

    access(1, a_w, 32'hDEAD_BEEF, 4'b0101, rd, st);
    chk("R7 store no stall", st, 0);
    access(0, a_w, 0, 0, rd, st);
    chk("R5 store hit keeps line", st, 0);
    chk("R5 byte merge", rd, merge(init_word(a_w[31:2]), 32'hDEAD_BEEF, 4'b0101));

    access(1, c_w, 32'h1234_5678, 4'b1111, rd, st);
    access(0, c_w, 0, 0, rd, st);
    chk("R8 no allocate", {31'b0, st > 0}, 32'd1);
    chk("R9 read after buffered store", rd, 32'h1234_5678);

    access(1, d_w, 32'hAAAA_0001, 4'b1111, rd, st);
    access(1, d_w, 32'hBBBB_0002, 4'b0011, rd, st);
    access(0, d_w, 0, 0, rd, st);
    chk("R10 order", rd, 32'hAAAA_0002);
    idle(60);
    chk("R6 mem A", mem_get(a_w[31:2]), gold_get(a_w[31:2]));
    chk("R6 mem C", mem_get(c_w[31:2]), 32'h1234_5678);
    chk("R10 mem D", mem_get(d_w[31:2]), 32'hAAAA_0002);

    // buffer full behaviour
    lat = 20;
    idle(10);
    s4 = 0;
    for (int i = 0; i < 4; i++) begin
      access(1, 32'h0001_0000 + 32'(i * 4), 32'(i), 4'b1111, rd, st);
      s4 += st;
    end
    chk("R7 four stores free", s4, 0);
    access(1, 32'h0001_0010, 32'h55, 4'b1111, rd, st);
    chk("R7 fifth store stalls", {31'b0, st > 0}, 32'd1);
    idle(150);
    chk("R6 drained word", mem_get(32'h0001_0010 >> 2), 32'h55);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] ra;
      logic [3:0]  rbe;
      lat = int'($urandom_range(0, 6));
      ra  = {18'(($urandom % 3) + 1), 2'b0, 7'($urandom % 8), 3'b0, 2'($urandom % 4)};
      if ($urandom % 3 == 0) begin
        rbe = 4'($urandom_range(1, 15));
        access(1, ra, $urandom, rbe, rd, st);
      end else begin
        exp_w = gold_get(ra[31:2]);
        access(0, ra, 0, 0, rd, st);
        chk("R4/R9 random load", rd, exp_w);
      end
    end
    lat = 2;
    idle(100);
    foreach (gold_m[w]) chk("R6 final memory", mem_get(w), gold_m[w]);

    done = 1'b1;
    report();
  end
endmodule